// File: doc/BRIEF.md
# Power-Down Sequencing Unit

This unit decides when a processor core may enter a dormant low-power state and how it comes back. Software first sets an enable bit in a memory-mapped control word. A level-2 interrupt then arms the sequence. The interrupt can come from a pin or from a software force strobe. The handler may run any number of instructions. An IDLE executed inside that handler stops the core and, if selected, switches the crystal oscillator off. An RTI executed before the IDLE abandons the attempt.

While dormant, the unit raises an acknowledge output. It leaves the dormant state on a rising edge of a synchronised wake-flag pin. If the oscillator was switched off, the unit holds the core for a fixed stabilisation count before it releases it. On release it gives a one-cycle pulse that tells the core either to resume its saved context or to perform a soft context reset.

The states are RUN, ARMED (the IRQ2 handler is running with the sequence armed), DORMANT, OSC_WAIT and WAKE. The transitions are:
- RUN→ARMED on IRQ2 with the enable bit set.
- ARMED→DORMANT on IDLE.
- ARMED→RUN on RTI (abort).
- DORMANT→OSC_WAIT on a wake edge when the crystal-off bit is set.
- DORMANT→WAKE on a wake edge when the crystal-off bit is clear.
- OSC_WAIT→WAKE when the count expires.
- WAKE→RUN always, after one cycle.
- Asynchronous reset sends any state to RUN.

Top module: `pd_unit`

## Requirements
- R1: The control word sits at address 0x3FEF. Its fields are bit 15 crystal-off, bit 13 enable and bit 12 context-reset select. It resets to all zeros. A write to any other address leaves it unchanged. A read of any other address returns 0.
- R2: Read bit 14 returns the synchronised wake-flag pin level while enable is 1. It returns 0 while enable is 0. Writes to bit 14 have no effect.
- R3: `irq2_ack_o` is high in the same cycle as IRQ2 (`irq2_pin_i` or `irq2_force_i`) whenever the unit is in RUN. If enable is 0, the interrupt is a normal one: a later IDLE does not halt the core.
- R4: An IDLE while ARMED enters DORMANT at the next edge. In DORMANT, `core_halt_o` is 1, `pwd_ack_o` is 1 and `osc_off_o` equals the crystal-off bit.
- R5: An RTI while ARMED returns the unit to RUN at the next edge. A later IDLE then has no effect. If IDLE and RTI arrive in the same cycle, IDLE wins.
- R6: DORMANT is left only on a low-to-high transition of the synchronised wake-flag while enable is 1. The unit leaves DORMANT at the third rising clock edge after the pin rises, and `pwd_ack_o` falls in that same cycle. A pin that is already high at entry does not wake the unit.
- R7: If the crystal-off bit is set, the unit holds OSC_WAIT for exactly OSC_CYCLES (default 4096) cycles. During that time `core_halt_o` is 1 and `osc_off_o` is 0.
- R8: WAKE lasts one cycle with `core_halt_o` at 0. In that cycle `ctx_reset_o` pulses if the context-reset bit is 1, and `resume_o` pulses otherwise. The unit is then in RUN.
- R9: Asserting `rst_n` low, including while dormant, returns the unit to RUN. All outputs go low and the control word clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 14 | Data-memory address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| irq2_pin_i | input | 1 | External level-2 interrupt |
| irq2_force_i | input | 1 | Software interrupt force strobe |
| seq_idle_i | input | 1 | IDLE executed |
| seq_rti_i | input | 1 | RTI executed |
| wake_flag_i | input | 1 | Asynchronous wake-flag pin |
| irq2_ack_o | output | 1 | Interrupt taken (vector 0x0004) |
| pwd_ack_o | output | 1 | Dormant acknowledge |
| osc_off_o | output | 1 | Crystal oscillator disable |
| core_halt_o | output | 1 | Core halt |
| ctx_reset_o | output | 1 | Soft context reset pulse |
| resume_o | output | 1 | Resume-context pulse |

## Verification
Several results appear at different times after their stimulus:
- `irq2_ack_o` and read data are combinational, so they are checked in the same cycle as their stimulus.
- Register writes, IDLE and RTI take effect at the next edge.
- A wake-pin rise is seen three edges later, after the two synchroniser stages and the state register.
- The oscillator wait ends OSC_CYCLES edges after that.

The bench drives all inputs and samples all outputs at the falling edge. It counts edges explicitly to each of these points, including the last cycle before each change, so a result that arrives one cycle early or late is reported.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [2:0] {
        PD_RUN      = 3'd0,
        PD_ARMED    = 3'd1,
        PD_DORMANT  = 3'd2,
        PD_OSC_WAIT = 3'd3,
        PD_WAKE     = 3'd4
    } pd_state_t;

    typedef struct packed {
        logic xtal_off;
        logic enable;
        logic ctx_rst;
    } pd_ctrl_t;

    localparam int unsigned XTAL_BIT = 15;
    localparam int unsigned FLAG_BIT = 14;
    localparam int unsigned ENA_BIT  = 13;
    localparam int unsigned CTX_BIT  = 12;

endpackage

// File: rtl/pd_flag_sync.sv
module pd_flag_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin_i};
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/pd_ctrl_reg.sv
module pd_ctrl_reg
    import pd_pkg::*;
#(
    parameter int unsigned     AW   = 14,
    parameter int unsigned     DW   = 16,
    parameter logic [AW-1:0]   ADDR = 14'h3FEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          flag_level_i,
    output pd_ctrl_t      ctrl_o
);
    logic hit;
    assign hit = (bus_addr_i == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (bus_wr_i && hit) begin
            ctrl_o.xtal_off <= bus_wdata_i[XTAL_BIT];
            ctrl_o.enable   <= bus_wdata_i[ENA_BIT];
            ctrl_o.ctx_rst  <= bus_wdata_i[CTX_BIT];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit) begin
            bus_rdata_o[XTAL_BIT] = ctrl_o.xtal_off;
            bus_rdata_o[FLAG_BIT] = ctrl_o.enable & flag_level_i;
            bus_rdata_o[ENA_BIT]  = ctrl_o.enable;
            bus_rdata_o[CTX_BIT]  = ctrl_o.ctx_rst;
        end
    end

    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !hit) |=> $stable(ctrl_o)); // R1
    AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o.enable |-> !bus_rdata_o[FLAG_BIT]); // R2

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_pkg::*;
#(
    parameter int unsigned OSC_CYCLES = 4096
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     irq2_i,
    input  logic     idle_i,
    input  logic     rti_i,
    input  logic     wake_edge_i,
    input  pd_ctrl_t ctrl_i,
    output logic     irq2_ack_o,
    output logic     pwd_ack_o,
    output logic     osc_off_o,
    output logic     core_halt_o,
    output logic     ctx_reset_o,
    output logic     resume_o
);
    localparam int unsigned CW = (OSC_CYCLES > 2) ? $clog2(OSC_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OSC_CYCLES - 1);

    pd_state_t state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            PD_RUN:      if (irq2_i && ctrl_i.enable) nxt = PD_ARMED;
            PD_ARMED:    if (idle_i)     nxt = PD_DORMANT;
                         else if (rti_i) nxt = PD_RUN;
            PD_DORMANT:  if (wake_edge_i)
                             nxt = ctrl_i.xtal_off ? PD_OSC_WAIT : PD_WAKE;
            PD_OSC_WAIT: if (cnt == CNT_LAST) nxt = PD_WAKE;
            PD_WAKE:     nxt = PD_RUN;
            default:     nxt = PD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PD_OSC_WAIT) cnt <= cnt + 1'b1;
            else                      cnt <= '0;
        end
    end

    always_comb begin
        irq2_ack_o  = 1'b0;
        pwd_ack_o   = 1'b0;
        osc_off_o   = 1'b0;
        core_halt_o = 1'b0;
        ctx_reset_o = 1'b0;
        resume_o    = 1'b0;
        unique case (state)
            PD_RUN:      irq2_ack_o = irq2_i;
            PD_ARMED:    ;
            PD_DORMANT: begin
                core_halt_o = 1'b1;
                pwd_ack_o   = ctrl_i.enable;
                osc_off_o   = ctrl_i.xtal_off;
            end
            PD_OSC_WAIT: core_halt_o = 1'b1;
            PD_WAKE: begin
                ctx_reset_o = ctrl_i.ctx_rst;
                resume_o    = ~ctrl_i.ctx_rst;
            end
            default: ;
        endcase
    end

    AST_DORMANT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_DORMANT && $past(state) != PD_DORMANT) |-> ($past(state) == PD_ARMED && $past(idle_i))); // R4
    AST_RTI_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_ARMED && rti_i && !idle_i) |=> state == PD_RUN); // R5
    AST_EXIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PD_DORMANT && state != PD_DORMANT) |-> $past(wake_edge_i)); // R6
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_OSC_WAIT) |-> (cnt <= CNT_LAST)); // R7

endmodule

// File: rtl/pd_unit.sv
module pd_unit
    import pd_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 14,
    parameter int unsigned       DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 14'h3FEF,
    parameter int unsigned       OSC_CYCLES  = 4096,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              irq2_pin_i,
    input  logic              irq2_force_i,
    input  logic              seq_idle_i,
    input  logic              seq_rti_i,
    input  logic              wake_flag_i,
    output logic              irq2_ack_o,
    output logic              pwd_ack_o,
    output logic              osc_off_o,
    output logic              core_halt_o,
    output logic              ctx_reset_o,
    output logic              resume_o
);
    pd_ctrl_t ctrl;
    logic     flag_level, flag_rise, wake_edge;

    pd_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(wake_flag_i),
        .level_o(flag_level), .rise_o(flag_rise)
    );

    pd_ctrl_reg #(.AW(ADDR_W), .DW(DATA_W), .ADDR(CTRL_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .flag_level_i(flag_level), .ctrl_o(ctrl)
    );

    assign wake_edge = flag_rise & ctrl.enable;

    pd_seq_fsm #(.OSC_CYCLES(OSC_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .irq2_i(irq2_pin_i | irq2_force_i),
        .idle_i(seq_idle_i), .rti_i(seq_rti_i), .wake_edge_i(wake_edge),
        .ctrl_i(ctrl), .irq2_ack_o(irq2_ack_o), .pwd_ack_o(pwd_ack_o),
        .osc_off_o(osc_off_o), .core_halt_o(core_halt_o),
        .ctx_reset_o(ctx_reset_o), .resume_o(resume_o)
    );

    AST_ACK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        pwd_ack_o |-> core_halt_o); // R4
    AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_reset_o || resume_o) |-> (!core_halt_o && !osc_off_o)); // R8
    AST_ACK_FALL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwd_ack_o) && ctrl.enable) |-> $past(wake_edge)); // R6

endmodule

// File: tb/sim_pd_unit.sv
`timescale 1ns/1ps
module sim_pd_unit;
    localparam int OSC = 4096;
    localparam logic [13:0] REG = 14'h3FEF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic irq_pin = 0, irq_force = 0, idle = 0, rti = 0, flag = 0;
    logic irq_ack, pwd_ack, osc_off, halt, ctx_rst, resume;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pd_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq2_pin_i(irq_pin),
        .irq2_force_i(irq_force), .seq_idle_i(idle), .seq_rti_i(rti),
        .wake_flag_i(flag), .irq2_ack_o(irq_ack), .pwd_ack_o(pwd_ack),
        .osc_off_o(osc_off), .core_halt_o(halt), .ctx_reset_o(ctx_rst),
        .resume_o(resume)
    );

    function automatic logic [15:0] exp_rd(logic [15:0] w, logic pin);
        logic [15:0] r = '0;
        r[15] = w[15]; r[13] = w[13]; r[12] = w[12];
        r[14] = w[13] & pin;
        return r;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [13:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0; bus_addr = REG;
    endtask

    task automatic rd(output logic [15:0] d);
        bus_addr = REG; #1 d = bus_rdata;
    endtask

    task automatic run_pd(logic xtal, logic pucr, logic abort);
        logic [15:0] w;
        w = {xtal, 1'b0, 1'b1, pucr, 12'h0};
        wr(REG, w); flag = 0; tick(3);
        irq_force = 1; #1 chk("R3 irq ack", irq_ack, 1);
        tick(); irq_force = 0;
        chk("R3 armed no halt", halt, 0);
        tick($urandom_range(0, 5));
        if (abort) begin
            rti = 1; tick(); rti = 0;
            idle = 1; tick(); idle = 0;
            chk("R5 idle after rti ignored", {halt, pwd_ack}, 0);
            return;
        end
        idle = 1; tick(); idle = 0;
        chk("R4 dormant", {halt, pwd_ack, osc_off}, {1'b1, 1'b1, xtal});
        tick($urandom_range(0, 10));
        chk("R4 holds", {halt, pwd_ack}, 2'b11);
        flag = 1; tick(2);
        chk("R6 ack before 3rd edge", pwd_ack, 1);
        tick();
        chk("R6 ack falls", pwd_ack, 0);
        if (xtal) begin
            chk("R7 wait start", {halt, osc_off}, 2'b10);
            tick(OSC - 1);
            chk("R7 last wait cycle", {halt, ctx_rst, resume}, 3'b100);
            tick();
        end
        chk("R8 wake", {halt, ctx_rst, resume}, {1'b0, pucr, ~pucr});
        tick();
        chk("R8 back to run", {halt, ctx_rst, resume}, 0);
        flag = 0; tick(3);
    endtask

    initial begin
        logic [15:0] d, w, exp_w;
        process::self().srandom(32'h5EED_0042);
        tick(2);
        rd(d); chk("R9 reset word", d, 0);
        chk("R9 reset outputs", {irq_ack, pwd_ack, osc_off, halt, ctx_rst, resume}, 0);
        rst_n = 1; tick();
        rd(d); chk("R1 reset default", d, 0);

        exp_w = 0;
        for (int i = 0; i < 30; i++) begin
            logic [13:0] a;
            w = 16'($urandom());
            a = ($urandom_range(0, 1) == 0) ? REG : 14'($urandom());
            flag = 1'($urandom());
            wr(a, w);
            if (a == REG) exp_w = w;
            tick(3);
            rd(d); chk("R1/R2 readback", d, exp_rd(exp_w, flag));
            bus_addr = a ^ 14'h0001; #1 chk("R1 other addr reads 0", bus_rdata, 0);
            bus_addr = REG;
        end
        flag = 0; tick(3);

        wr(REG, 16'h0000);
        irq_pin = 1; #1 chk("R3 normal irq ack", irq_ack, 1);
        tick(); irq_pin = 0;
        idle = 1; tick(); idle = 0;
        chk("R3 normal irq no halt", {halt, pwd_ack}, 0);

        for (int i = 0; i < 8; i++)
            run_pd(1'($urandom()), 1'($urandom()), (i % 4) == 3);
        run_pd(1'b1, 1'b1, 1'b0);
        run_pd(1'b0, 1'b0, 1'b0);

        wr(REG, 16'h2000); irq_force = 1; tick(); irq_force = 0;
        idle = 1; rti = 1; tick(); idle = 0; rti = 0;
        chk("R5 idle wins over rti", halt, 1);
        flag = 1; tick(3); flag = 0; tick(4);

        flag = 1; tick(3);
        irq_force = 1; tick(); irq_force = 0;
        idle = 1; tick(); idle = 0;
        tick(10);
        chk("R6 high pin no wake", pwd_ack, 1);
        flag = 0; tick(3); flag = 1; tick(3);
        chk("R6 wake after fresh edge", {halt, resume}, 2'b01);
        tick(); flag = 0; tick(3);

        irq_force = 1; tick(); irq_force = 0;
        idle = 1; tick(); idle = 0;
        chk("R4 dormant before reset", halt, 1);
        rst_n = 0; #1;
        chk("R9 reset exits dormant", {pwd_ack, halt, osc_off}, 0);
        rd(d); chk("R9 word cleared", d, 0);
        tick(); rst_n = 1; tick();
        chk("R9 run after reset", halt, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule